// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter Channel

This block is one timer/counter channel of the kind found in small 8-bit controllers. It keeps its count in a low byte and a high byte. It advances on one of two sources: a tick from a free-running divide-by-six prescaler on the system clock, or a falling edge on an external event pin. A run bit enables counting. When the gate bit is set, a gate pin must also be high for counting to happen, so the channel can measure how long a pulse on that pin lasts.

Three counting layouts are supported:

- a 13-bit counter, made of the whole high byte and the low five bits of the low byte;
- a plain 16-bit counter;
- an 8-bit counter in the low byte that reloads itself from the high byte.

A wrap from all ones sets a sticky overflow flag. Software clears the flag with a one-cycle strobe. Software presets the count bytes through a plain write strobe, and the two bytes can be read at all times as output ports.

The channel has no streaming data path, so there is no valid/ready handshake. The write strobe and the flag-clear strobe are always accepted in the cycle they are asserted, and the block never pushes back.

Top module: `tmr_chan`

## Requirements
- R1: The prescaler is reset to zero and then runs freely, whatever the run bit is. Its first tick falls on the sixth rising clock edge after reset is released, and a tick follows every six cycles after that. In timer mode (`cfg_ext_src`=0), an enabled counter advances once per tick.
- R2: Counting is enabled only when `cfg_run`=1 and either `cfg_gate`=0 or `gate_in`=1. While counting is disabled, the count bytes hold their values.
- R3: With `cfg_ext_src`=1, `evt_in` is sampled on each tick. A sample of 1 followed by a sample of 0 on the next tick counts one event, and that event is counted on the tick that sees the 0.
- R4: With `cfg_mode`=0, the count is 13 bits wide: `cnt_hi` supplies the upper 8 bits and `cnt_lo[4:0]` the lower 5 bits. `cnt_lo[7:5]` never changes through counting. A wrap from 0x1FFF to 0 sets the flag.
- R5: With `cfg_mode`=1, `{cnt_hi,cnt_lo}` counts as 16 bits. A wrap from 0xFFFF to 0 sets the flag.
- R6: With `cfg_mode`=2, only `cnt_lo` counts. When it advances from 0xFF, it takes the value of `cnt_hi` and the flag is set. `cnt_hi` never changes through counting.
- R7: Turning on the run bit does not clear the count. Counting continues from the value held or preset.
- R8: The flag stays set until a `clr_flag` strobe clears it. If an overflow happens in the same cycle as the strobe, the flag ends up set.
- R9: A write (`wr_en`=1; `wr_sel`=0 writes the low byte, 1 writes the high byte) replaces the chosen byte on the next edge. In that cycle no count step takes place in either byte.
- R10: With `cfg_mode`=3, nothing counts. The count bytes and the flag hold their values, but writes and clears still work.
- R11: Reset clears both count bytes and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Count-byte write strobe |
| wr_sel | input | 1 | Byte select for a write: 0 = low, 1 = high |
| wr_data | input | 8 | Value to write |
| clr_flag | input | 1 | One-cycle strobe that clears the overflow flag |
| cfg_run | input | 1 | Run bit |
| cfg_gate | input | 1 | When 1, counting also needs `gate_in` high |
| cfg_ext_src | input | 1 | Count source: 0 = prescaler tick, 1 = events on `evt_in` |
| cfg_mode | input | 2 | 0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = halt |
| gate_in | input | 1 | External gate level |
| evt_in | input | 1 | External event pin |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `gate_in`, `evt_in` and all configuration inputs are synchronous to `clk`. They also assume that the configuration is not changed in the same cycle as a count step the checks rely on. The stimulus drives every input on the falling clock edge and changes the mode and source only while the run bit is low. It holds each `evt_in` level for two full prescaler periods, so every edge is seen by exactly one pair of tick samples. The bench lines up writes and flag clears with the hidden tick phase by watching the count change, without looking inside the design.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13   = 2'd0,
    MD_16   = 2'd1,
    MD_RLD  = 2'd2,
    MD_HALT = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] STEP = PW'(1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + STEP;
  end

  // two ticks never come back to back
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/tmr_evt_edge.sv
`timescale 1ns/1ps
module tmr_evt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic evt_in,
  output logic fall
);
  logic last_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_smp <= 1'b0;
    else if (tick) last_smp <= evt_in;
  end

  assign fall = tick & last_smp & ~evt_in;
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW    = 8,
  parameter int M0_LO = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  tmr_mode_e     mode,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          clr,
  output logic [CW-1:0] lo,
  output logic [CW-1:0] hi,
  output logic          flag
);
  localparam int M0W = CW + M0_LO;
  localparam logic [M0W:0]  ONE_M0  = (M0W+1)'(1);
  localparam logic [2*CW:0] ONE_M1  = (2*CW+1)'(1);
  localparam logic [CW-1:0] ONE_B   = CW'(1);

  logic [M0W:0]  sum_m0;
  logic [2*CW:0] sum_m1;
  logic [CW-1:0] lo_n, hi_n;
  logic          wrap;

  assign sum_m0 = {1'b0, hi, lo[M0_LO-1:0]} + ONE_M0;
  assign sum_m1 = {1'b0, hi, lo} + ONE_M1;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    wrap = 1'b0;
    if (wr_en) begin
      if (wr_sel) hi_n = wr_data;
      else        lo_n = wr_data;
    end else if (step) begin
      case (mode)
        MD_13: begin
          lo_n = {lo[CW-1:M0_LO], sum_m0[M0_LO-1:0]};
          hi_n = sum_m0[M0W-1:M0_LO];
          wrap = sum_m0[M0W];
        end
        MD_16: begin
          lo_n = sum_m1[CW-1:0];
          hi_n = sum_m1[2*CW-1:CW];
          wrap = sum_m1[2*CW];
        end
        MD_RLD: begin
          if (&lo) begin
            lo_n = hi;
            wrap = 1'b1;
          end else begin
            lo_n = lo + ONE_B;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo   <= '0;
      hi   <= '0;
      flag <= 1'b0;
    end else begin
      lo   <= lo_n;
      hi   <= hi_n;
      flag <= wrap | (flag & ~clr);
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (lo == $past(wr_data))); // R9
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HALT && !wr_en) |=> ($stable(lo) && $stable(hi))); // R10
  AST_RELOAD_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RLD && !wr_en) |=> $stable(hi)); // R6
  AST_M0_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_13 && !wr_en) |=> $stable(lo[CW-1:M0_LO])); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en) |=> ($stable(lo) && $stable(hi))); // R7
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DIV   = 6,
  parameter int CW    = 8,
  parameter int M0_LO = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          clr_flag,
  input  logic          cfg_run,
  input  logic          cfg_gate,
  input  logic          cfg_ext_src,
  input  logic [1:0]    cfg_mode,
  input  logic          gate_in,
  input  logic          evt_in,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic          ovf_flag
);
  tmr_mode_e mode;
  logic      tick, fall, enable, step;

  assign mode   = tmr_mode_e'(cfg_mode);
  assign enable = cfg_run & (~cfg_gate | gate_in) & (mode != MD_HALT);
  assign step   = enable & (cfg_ext_src ? fall : tick);

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  tmr_evt_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .evt_in (evt_in),
    .fall   (fall)
  );

  tmr_core #(.CW(CW), .M0_LO(M0_LO)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .mode    (mode),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .clr     (clr_flag),
    .lo      (cnt_lo),
    .hi      (cnt_hi),
    .flag    (ovf_flag)
  );

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run && cfg_gate && !gate_in && !wr_en) |=>
      ($stable(cnt_lo) && $stable(cnt_hi))); // R2
  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R2
endmodule

// File: tb/tmr_chan_bench.sv
`timescale 1ns/1ps
module tmr_chan_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, clr_flag = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cfg_run = 1'b0, cfg_gate = 1'b0, cfg_ext_src = 1'b0;
  logic [1:0] cfg_mode = 2'd1;
  logic       gate_in = 1'b0, evt_in = 1'b0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       ovf_flag;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  tmr_chan u_tmr_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_flag(clr_flag), .cfg_run(cfg_run), .cfg_gate(cfg_gate),
    .cfg_ext_src(cfg_ext_src), .cfg_mode(cfg_mode), .gate_in(gate_in),
    .evt_in(evt_in), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] n;
    logic [7:0] ehi;
    logic [7:0] elo;
    logic       ef;
  } vec_t;

  // mode, preset hi/lo, ticks, expected hi/lo/flag
  localparam vec_t VECS [10] = '{
    '{2'd1, 8'h00, 8'h00, 8'd5, 8'h00, 8'h05, 1'b0},  // R5 plain
    '{2'd1, 8'h00, 8'hFE, 8'd3, 8'h01, 8'h01, 1'b0},  // R5 byte carry
    '{2'd1, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},  // R5 wrap
    '{2'd0, 8'h00, 8'h1F, 8'd1, 8'h01, 8'h00, 1'b0},  // R4 carry at bit 5
    '{2'd0, 8'h00, 8'hFF, 8'd1, 8'h01, 8'hE0, 1'b0},  // R4 top bits kept
    '{2'd0, 8'hFF, 8'h1F, 8'd2, 8'h00, 8'h01, 1'b1},  // R4 wrap
    '{2'd0, 8'hFF, 8'hBF, 8'd1, 8'h00, 8'hA0, 1'b1},  // R4 wrap, top bits kept
    '{2'd2, 8'h80, 8'hFE, 8'd3, 8'h80, 8'h81, 1'b1},  // R6 reload
    '{2'd2, 8'h10, 8'h20, 8'd4, 8'h10, 8'h24, 1'b0},  // R6 no reload
    '{2'd3, 8'h12, 8'h34, 8'd5, 8'h12, 8'h34, 1'b0}   // R10 halt
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
  endtask

  task automatic wait_lo(input logic [7:0] val);
    int guard = 0;
    while (cnt_lo !== val && guard < 40) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset lo/hi", {cnt_hi, cnt_lo}, 16'h0000);
    check("R11 reset flag", {15'd0, ovf_flag}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", {cnt_hi, cnt_lo}, 16'h0000);

    // table walk: R4 R5 R6 R10, presets then run (R7)
    for (int i = 0; i < 10; i++) begin
      cfg_run = 1'b0;
      cfg_mode = VECS[i].mode;
      wr_byte(1'b1, VECS[i].hi);
      wr_byte(1'b0, VECS[i].lo);
      pulse_clr();
      cfg_run = 1'b1;
      repeat (6 * int'(VECS[i].n)) @(negedge clk);
      cfg_run = 1'b0;
      @(negedge clk);
      check($sformatf("R7 vector %0d count", i), {cnt_hi, cnt_lo}, {VECS[i].ehi, VECS[i].elo});
      check($sformatf("R8 vector %0d flag", i), {15'd0, ovf_flag}, {15'd0, VECS[i].ef});
    end

    // R1 tick spacing, found through the count itself
    cfg_mode = 2'd1;
    wr_byte(1'b1, 8'h00);
    wr_byte(1'b0, 8'h00);
    cfg_run = 1'b1;
    wait_lo(8'h01);
    repeat (5) @(negedge clk);
    check("R1 no step before sixth edge", {8'h00, cnt_lo}, 16'h0001);
    @(negedge clk);
    check("R1 step on sixth edge", {8'h00, cnt_lo}, 16'h0002);

    // R9 write lands on a tick cycle
    repeat (5) @(negedge clk);
    wr_byte(1'b0, 8'h40);
    check("R9 write beats step", {cnt_hi, cnt_lo}, 16'h0040);
    repeat (6) @(negedge clk);
    check("R9 counting resumes", {cnt_hi, cnt_lo}, 16'h0041);
    cfg_run = 1'b0;

    // R8 set wins over clear
    wr_byte(1'b1, 8'hFF);
    wr_byte(1'b0, 8'hFD);
    pulse_clr();
    check("R8 cleared", {15'd0, ovf_flag}, 16'd0);
    cfg_run = 1'b1;
    wait_lo(8'hFF);
    repeat (5) @(negedge clk);
    pulse_clr();
    check("R8 set wins", {15'd0, ovf_flag}, 16'd1);
    check("R5 wrapped on clear cycle", {cnt_hi, cnt_lo}, 16'h0000);
    cfg_run = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 sticky", {15'd0, ovf_flag}, 16'd1);
    pulse_clr();
    check("R8 clear strobe", {15'd0, ovf_flag}, 16'd0);

    // R2 gate
    wr_byte(1'b1, 8'h00);
    wr_byte(1'b0, 8'h00);
    cfg_gate = 1'b1; gate_in = 1'b0; cfg_run = 1'b1;
    repeat (12) @(negedge clk);
    check("R2 gate low blocks", {cnt_hi, cnt_lo}, 16'h0000);
    gate_in = 1'b1;
    repeat (12) @(negedge clk);
    cfg_run = 1'b0;
    @(negedge clk);
    check("R2 gate high counts", {cnt_hi, cnt_lo}, 16'h0002);
    cfg_gate = 1'b0; gate_in = 1'b0;

    // R3 external events
    wr_byte(1'b0, 8'h00);
    cfg_ext_src = 1'b1; evt_in = 1'b1;
    repeat (12) @(negedge clk);
    cfg_run = 1'b1;
    for (int k = 0; k < 3; k++) begin
      evt_in = 1'b0;
      repeat (12) @(negedge clk);
      evt_in = 1'b1;
      repeat (12) @(negedge clk);
    end
    cfg_run = 1'b0;
    @(negedge clk);
    check("R3 three falling edges", {cnt_hi, cnt_lo}, 16'h0003);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule